// File: doc/BRIEF.md
# Load Memory Issue Controller

This block takes one load per cycle that must go to memory and turns it into one or two data-cache requests. A load marked uncacheable goes out only when it is non-speculative: it must be the oldest load in its queue and ready to commit. If it is not, the load is sent back for rescheduling with a fault code. A load that crosses an alignment boundary arrives pre-split into a low part and a high part. The block sends both parts in the same cycle and tracks how many of them are still outstanding.

The cache answers each request in the same cycle with accept or refuse. A refusal, or a cache that is already blocked, raises a retry indication. It also records the oldest load that hit the blockage, so that an outer pipeline can squash that load and fetch it again. The outer logic clears that record and acknowledges it through two control inputs.

Responses come back by load-queue index. When the last outstanding part of a live load returns, the block reports completion. A load is no longer live once a squash has passed over it, and its responses are then dropped.

Top module: `lmi_ctrl`

## Requirements
- R1: An uncacheable load that is not both at the queue head and ready to commit sends no request, pulses `resched`, and drives `fault_code` 4'hC. Otherwise `fault_code` is 4'h0, and an eligible uncacheable load issues like any other.
- R2: `req0_cmd`/`req1_cmd` carry 2'd2 for a load-locked load and 2'd1 for a plain read. A load-locked load is never split: its `ld_split` input is ignored, so one request of size `ld_size` is sent.
- R3: A split load drives request 0 with `ld_addr` and size `ld_lo_size`. It drives request 1 with address `ld_addr + ld_lo_size`, size `ld_hi_size` and data offset `ld_lo_size`. A non-split load uses size `ld_size` on request 0.
- R4: `ports_used` equals the number of requests presented in the cycle (0, 1 or 2). It counts afresh every cycle. Request 1 is presented only when request 0 is accepted in that cycle. No request is presented while `cache_blocked` is high.
- R5: If request 0 is refused, `retry_req` is high and nothing is recorded as outstanding for that load. The same index can then be issued again and completes on its own responses.
- R6: If only request 1 of a split load is refused, `retry_req` is high and a single response completes the load.
- R7: `done_valid` is high, with `done_idx`/`done_seq` of the load, in the cycle of the response that brings its outstanding count to zero. An accepted split load needs two responses; other loads need one.
- R8: A load that finds the cache blocked or has a request refused updates the blocked record, visible from the next cycle. The update happens only if no load is recorded yet or the new load's sequence number is not greater than the recorded one. An update sets `blk_flag`, stores `blk_seq` and clears `blk_handled`.
- R9: `blk_clear` drops `blk_flag` and `blk_handled_set` raises `blk_handled` on the next cycle. A blockage recorded in the same cycle takes precedence over both.
- R10: After `squash_valid` with `squash_seq`, loads whose sequence number is greater than `squash_seq` give no `done_valid` when their last response returns.
- R11: After reset, no request, retry, reschedule or completion is signalled, `blk_flag` and `blk_handled` are 0, and `fault_code` is 4'h0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | A load is offered this cycle |
| ld_idx | input | IDX_W | Load-queue index of the load |
| ld_seq | input | SEQ_W | Sequence number (smaller is older) |
| ld_addr | input | ADDR_W | Load address |
| ld_size | input | SZ_W | Size in bytes of an unsplit load |
| ld_uncache | input | 1 | Load is uncacheable |
| ld_locked | input | 1 | Load-locked load |
| ld_split | input | 1 | Load is split into two parts |
| ld_lo_size | input | SZ_W | Size of the low part |
| ld_hi_size | input | SZ_W | Size of the high part |
| ld_at_head | input | 1 | Load is at the queue head |
| ld_at_commit | input | 1 | Load is ready to commit |
| cache_blocked | input | 1 | Cache is refusing all traffic |
| req0_valid | output | 1 | First request presented |
| req0_accept | input | 1 | Cache accepts the first request |
| req0_cmd | output | 2 | 1 read, 2 load-locked |
| req0_addr | output | ADDR_W | First request address |
| req0_size | output | SZ_W | First request size |
| req1_valid | output | 1 | Second request presented |
| req1_accept | input | 1 | Cache accepts the second request |
| req1_cmd | output | 2 | 1 read, 2 load-locked |
| req1_addr | output | ADDR_W | Second request address |
| req1_size | output | SZ_W | Second request size |
| req1_offset | output | SZ_W | Data offset of the second part |
| ports_used | output | 2 | Cache ports used this cycle |
| retry_req | output | 1 | A request was refused |
| resched | output | 1 | Load sent back for rescheduling |
| fault_code | output | 4 | 4'hC on reschedule, else 4'h0 |
| rsp_valid | input | 1 | A response returns |
| rsp_idx | input | IDX_W | Load index of the response |
| done_valid | output | 1 | Load completed |
| done_idx | output | IDX_W | Index of the completed load |
| done_seq | output | SEQ_W | Sequence number of the completed load |
| squash_valid | input | 1 | Squash younger loads |
| squash_seq | input | SEQ_W | Loads with greater numbers are squashed |
| blk_clear | input | 1 | Clear the blocked record |
| blk_handled_set | input | 1 | Mark the blocked record handled |
| blk_flag | output | 1 | A load is recorded as blocked |
| blk_handled | output | 1 | Blocked record acknowledged |
| blk_seq | output | SEQ_W | Sequence number of the blocked load |

## Verification
The assertions take several things for granted about the inputs:
- responses arrive only for an index that has parts outstanding, and never for the index being issued in the same cycle;
- a new load is issued only to an index with nothing outstanding;
- sequence numbers do not wrap.

The stimulus keeps to these rules by holding a reference count per index and drawing issue and response indices only from free or busy entries respectively. Sequence numbers come from a counter that only increases, and squash points are drawn just below it.

// File: rtl/lmi_pkg.sv
package lmi_pkg;
    localparam logic [1:0] CMD_READ  = 2'd1;
    localparam logic [1:0] CMD_LLOCK = 2'd2;
    localparam logic [3:0] FLT_NONE  = 4'h0;
    localparam logic [3:0] FLT_MCHK  = 4'hC;
endpackage

// File: rtl/lmi_issue.sv
// lmi_issue: forms the cache requests for one offered load in the same cycle.
// Gates uncacheable loads on head+commit, applies split rules, counts ports
// and flags refusals. Assumes cache accept inputs are combinational replies.
module lmi_issue
    import lmi_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SZ_W   = 4
) (
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SZ_W-1:0]   ld_size,
    input  logic              ld_uncache,
    input  logic              ld_locked,
    input  logic              ld_split,
    input  logic [SZ_W-1:0]   ld_lo_size,
    input  logic [SZ_W-1:0]   ld_hi_size,
    input  logic              ld_at_head,
    input  logic              ld_at_commit,
    input  logic              cache_blocked,
    input  logic              req0_accept,
    input  logic              req1_accept,
    output logic              req0_valid,
    output logic [1:0]        req0_cmd,
    output logic [ADDR_W-1:0] req0_addr,
    output logic [SZ_W-1:0]   req0_size,
    output logic              req1_valid,
    output logic [1:0]        req1_cmd,
    output logic [ADDR_W-1:0] req1_addr,
    output logic [SZ_W-1:0]   req1_size,
    output logic [SZ_W-1:0]   req1_offset,
    output logic [1:0]        ports_used,
    output logic              retry_req,
    output logic              resched,
    output logic [3:0]        fault_code,
    output logic              go,
    output logic              split_eff,
    output logic              blk_event
);
    // Decide whether the load may issue and how many parts it has
    always_comb begin
        resched    = ld_valid && ld_uncache && !(ld_at_head && ld_at_commit);
        fault_code = resched ? FLT_MCHK : FLT_NONE;
        go         = ld_valid && !resched;
        split_eff  = ld_split && !ld_locked;
    end

    // Build both request slots; the second waits on the first's accept
    always_comb begin
        req0_valid  = go && !cache_blocked;
        req0_cmd    = ld_locked ? CMD_LLOCK : CMD_READ;
        req0_addr   = ld_addr;
        req0_size   = split_eff ? ld_lo_size : ld_size;
        req1_valid  = req0_valid && req0_accept && split_eff;
        req1_cmd    = req0_cmd;
        req1_addr   = ld_addr + ADDR_W'(ld_lo_size);
        req1_size   = ld_hi_size;
        req1_offset = ld_lo_size;
    end

    // Port count, refusal and blockage detection for this cycle
    always_comb begin
        ports_used = 2'(req0_valid) + 2'(req1_valid);
        retry_req  = (req0_valid && !req0_accept) || (req1_valid && !req1_accept);
        blk_event  = go && (cache_blocked || retry_req);
    end
endmodule

// File: rtl/lmi_track.sv
// lmi_track: per-index outstanding-part counters with liveness for squash.
// Assumes a response only targets an index with parts outstanding and never
// the index being written in the same cycle; sequence numbers do not wrap.
module lmi_track #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SEQ_W-1:0] wr_seq,
    input  logic [1:0]       wr_cnt,
    input  logic             rsp_valid,
    input  logic [IDX_W-1:0] rsp_idx,
    input  logic             squash_valid,
    input  logic [SEQ_W-1:0] squash_seq,
    output logic             done_valid,
    output logic [IDX_W-1:0] done_idx,
    output logic [SEQ_W-1:0] done_seq
);
    logic [1:0]       cnt_a   [DEPTH];
    logic             alive_a [DEPTH];
    logic [SEQ_W-1:0] seq_a   [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [1:0]       cnt_q;
        logic             alive_q;
        logic [SEQ_W-1:0] seq_q;
        logic             hit_wr;
        logic             alive_n;
        logic [SEQ_W-1:0] seq_n;

        // Next liveness: a new load is live unless the same-cycle squash covers it
        always_comb begin
            hit_wr  = wr_en && (wr_idx == IDX_W'(i));
            seq_n   = hit_wr ? wr_seq : seq_q;
            alive_n = hit_wr ? 1'b1 : alive_q;
            if (squash_valid && (seq_n > squash_seq))
                alive_n = 1'b0;
        end

        // Entry state update: allocate, count down responses, apply squash
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q   <= '0;
                alive_q <= 1'b0;
                seq_q   <= '0;
            end else begin
                if (hit_wr)
                    cnt_q <= wr_cnt;
                else if (rsp_valid && rsp_idx == IDX_W'(i) && cnt_q != 2'd0)
                    cnt_q <= cnt_q - 2'd1;
                alive_q <= alive_n;
                seq_q   <= seq_n;
            end
        end

        assign cnt_a[i]   = cnt_q;
        assign alive_a[i] = alive_q;
        assign seq_a[i]   = seq_q;
    end

    // Completion when the last part of a live load returns
    always_comb begin
        done_valid = rsp_valid && (cnt_a[rsp_idx] == 2'd1) && alive_a[rsp_idx];
        done_idx   = rsp_idx;
        done_seq   = seq_a[rsp_idx];
    end
endmodule

// File: rtl/lmi_block.sv
// lmi_block: keeps the oldest load that met a blocked or refusing cache.
// A new blockage wins over same-cycle clear and handled controls.
module lmi_block #(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_event,
    input  logic [SEQ_W-1:0] ev_seq,
    input  logic             blk_clear,
    input  logic             blk_handled_set,
    output logic             blk_flag,
    output logic             blk_handled,
    output logic [SEQ_W-1:0] blk_seq
);
    logic take;

    // Accept a new record if none is held or the newcomer is not younger
    always_comb take = blk_event && (!blk_flag || ev_seq <= blk_seq);

    // Record register with control inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_flag    <= 1'b0;
            blk_handled <= 1'b0;
            blk_seq     <= '0;
        end else if (take) begin
            blk_flag    <= 1'b1;
            blk_handled <= 1'b0;
            blk_seq     <= ev_seq;
        end else begin
            if (blk_clear)       blk_flag    <= 1'b0;
            if (blk_handled_set) blk_handled <= 1'b1;
        end
    end
endmodule

// File: rtl/lmi_ctrl.sv
// lmi_ctrl: top of the load memory issue controller. Joins request forming,
// outstanding tracking and blocked-load recording. Assumes one load offered
// per cycle and combinational accept replies from the cache.
module lmi_ctrl
    import lmi_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SZ_W   = 4,
    parameter int SEQ_W  = 16,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [SEQ_W-1:0]  ld_seq,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SZ_W-1:0]   ld_size,
    input  logic              ld_uncache,
    input  logic              ld_locked,
    input  logic              ld_split,
    input  logic [SZ_W-1:0]   ld_lo_size,
    input  logic [SZ_W-1:0]   ld_hi_size,
    input  logic              ld_at_head,
    input  logic              ld_at_commit,
    input  logic              cache_blocked,
    output logic              req0_valid,
    input  logic              req0_accept,
    output logic [1:0]        req0_cmd,
    output logic [ADDR_W-1:0] req0_addr,
    output logic [SZ_W-1:0]   req0_size,
    output logic              req1_valid,
    input  logic              req1_accept,
    output logic [1:0]        req1_cmd,
    output logic [ADDR_W-1:0] req1_addr,
    output logic [SZ_W-1:0]   req1_size,
    output logic [SZ_W-1:0]   req1_offset,
    output logic [1:0]        ports_used,
    output logic              retry_req,
    output logic              resched,
    output logic [3:0]        fault_code,
    input  logic              rsp_valid,
    input  logic [IDX_W-1:0]  rsp_idx,
    output logic              done_valid,
    output logic [IDX_W-1:0]  done_idx,
    output logic [SEQ_W-1:0]  done_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              blk_clear,
    input  logic              blk_handled_set,
    output logic              blk_flag,
    output logic              blk_handled,
    output logic [SEQ_W-1:0]  blk_seq
);
    logic       go;
    logic       split_eff;
    logic       blk_event;
    logic       wr_en;
    logic [1:0] wr_cnt;

    lmi_issue #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_issue (
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size),
        .ld_uncache(ld_uncache), .ld_locked(ld_locked), .ld_split(ld_split),
        .ld_lo_size(ld_lo_size), .ld_hi_size(ld_hi_size),
        .ld_at_head(ld_at_head), .ld_at_commit(ld_at_commit),
        .cache_blocked(cache_blocked),
        .req0_accept(req0_accept), .req1_accept(req1_accept),
        .req0_valid(req0_valid), .req0_cmd(req0_cmd), .req0_addr(req0_addr),
        .req0_size(req0_size),
        .req1_valid(req1_valid), .req1_cmd(req1_cmd), .req1_addr(req1_addr),
        .req1_size(req1_size), .req1_offset(req1_offset),
        .ports_used(ports_used), .retry_req(retry_req), .resched(resched),
        .fault_code(fault_code), .go(go), .split_eff(split_eff),
        .blk_event(blk_event)
    );

    // Outstanding count to record: only when the first part was accepted
    always_comb begin
        wr_en  = req0_valid && req0_accept;
        wr_cnt = (split_eff && req1_accept) ? 2'd2 : 2'd1;
    end

    lmi_track #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_track (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(ld_idx), .wr_seq(ld_seq), .wr_cnt(wr_cnt),
        .rsp_valid(rsp_valid), .rsp_idx(rsp_idx),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .done_valid(done_valid), .done_idx(done_idx), .done_seq(done_seq)
    );

    lmi_block #(.SEQ_W(SEQ_W)) u_block (
        .clk(clk), .rst_n(rst_n),
        .blk_event(blk_event), .ev_seq(ld_seq),
        .blk_clear(blk_clear), .blk_handled_set(blk_handled_set),
        .blk_flag(blk_flag), .blk_handled(blk_handled), .blk_seq(blk_seq)
    );
endmodule

// File: rtl/lmi_ctrl_chk.sv
// lmi_ctrl_chk: temporal checks on the controller's ports, bound to lmi_ctrl.
module lmi_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int SZ_W   = 4,
    parameter int SEQ_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_valid,
    input logic              ld_locked,
    input logic [SEQ_W-1:0]  ld_seq,
    input logic              req0_valid,
    input logic              req0_accept,
    input logic [ADDR_W-1:0] req0_addr,
    input logic [SZ_W-1:0]   req0_size,
    input logic              req1_valid,
    input logic [ADDR_W-1:0] req1_addr,
    input logic              resched,
    input logic              rsp_valid,
    input logic              done_valid,
    input logic              blk_flag,
    input logic              blk_handled,
    input logic [SEQ_W-1:0]  blk_seq,
    input logic              blk_clear
);
    // R1
    resched_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resched |-> !req0_valid && !req1_valid);

    // R4
    second_after_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req1_valid |-> req0_valid && req0_accept);

    // R2
    locked_unsplit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req0_valid && ld_locked) |-> !req1_valid);

    // R3
    high_part_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req1_valid |-> req1_addr == req0_addr + ADDR_W'(req0_size));

    // R7
    done_on_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> rsp_valid);

    // R8
    new_record_unhandled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_flag) |-> !blk_handled);

    // R9
    drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blk_flag) |-> $past(blk_clear));

    // R8
    record_never_younger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(blk_flag) && blk_flag && !$past(blk_clear)) |-> blk_seq <= $past(blk_seq));

    // R1
    resched_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resched |-> ld_valid);
endmodule

bind lmi_ctrl lmi_ctrl_chk #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .SEQ_W(SEQ_W)) u_chk (.*);

// File: tb/lmi_ctrl_tb.sv
module lmi_ctrl_tb;
    localparam int ADDR_W = 32;
    localparam int SZ_W   = 4;
    localparam int SEQ_W  = 16;
    localparam int DEPTH  = 8;
    localparam int IDX_W  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              ld_valid, ld_uncache, ld_locked, ld_split, ld_at_head, ld_at_commit;
    logic [IDX_W-1:0]  ld_idx, rsp_idx, done_idx;
    logic [SEQ_W-1:0]  ld_seq, squash_seq, done_seq, blk_seq;
    logic [ADDR_W-1:0] ld_addr, req0_addr, req1_addr;
    logic [SZ_W-1:0]   ld_size, ld_lo_size, ld_hi_size, req0_size, req1_size, req1_offset;
    logic              cache_blocked, req0_valid, req0_accept, req1_valid, req1_accept;
    logic [1:0]        req0_cmd, req1_cmd, ports_used;
    logic              retry_req, resched, rsp_valid, done_valid, squash_valid;
    logic [3:0]        fault_code;
    logic              blk_clear, blk_handled_set, blk_flag, blk_handled;

    lmi_ctrl u_dut (.*);

    int n_chk = 0;
    int n_bad = 0;
    int m_cnt [DEPTH];
    bit m_alive [DEPTH];
    logic [SEQ_W-1:0] m_seq [DEPTH];
    bit m_bflag, m_bhand;
    logic [SEQ_W-1:0] m_bseq;
    logic [SEQ_W-1:0] seq_ctr = 16'd10;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ld_valid = 0; ld_idx = 0; ld_seq = 0; ld_addr = 0; ld_size = 0;
        ld_uncache = 0; ld_locked = 0; ld_split = 0; ld_lo_size = 0; ld_hi_size = 0;
        ld_at_head = 0; ld_at_commit = 0; cache_blocked = 0;
        req0_accept = 1; req1_accept = 1; rsp_valid = 0; rsp_idx = 0;
        squash_valid = 0; squash_seq = 0; blk_clear = 0; blk_handled_set = 0;
    endtask

    // One cycle: inputs were set by the caller after a negedge
    task automatic step();
        bit rs, go, sp, r0, r1, rt, dn, ev, take;
        logic [SZ_W-1:0] s0;
        int ri;
        #1;
        rs = ld_valid && ld_uncache && !(ld_at_head && ld_at_commit);
        go = ld_valid && !rs;
        sp = ld_split && !ld_locked;
        r0 = go && !cache_blocked;
        r1 = r0 && req0_accept && sp;
        s0 = sp ? ld_lo_size : ld_size;
        rt = (r0 && !req0_accept) || (r1 && !req1_accept);
        ri = int'(rsp_idx);
        dn = rsp_valid && m_cnt[ri] == 1 && m_alive[ri];
        chk(resched == rs, "R1 resched", resched, rs);
        chk(fault_code == (rs ? 4'hC : 4'h0), "R1 fault_code", fault_code, rs ? 12 : 0);
        chk(req0_valid == r0, "R4 req0_valid", req0_valid, r0);
        chk(req1_valid == r1, "R3 req1_valid", req1_valid, r1);
        chk(ports_used == 2'(r0) + 2'(r1), "R4 ports_used", ports_used, 2'(r0) + 2'(r1));
        chk(retry_req == rt, "R5 retry_req", retry_req, rt);
        if (r0) begin
            chk(req0_cmd == (ld_locked ? 2'd2 : 2'd1), "R2 req0_cmd", req0_cmd, ld_locked ? 2 : 1);
            chk(req0_addr == ld_addr, "R3 req0_addr", req0_addr, ld_addr);
            chk(req0_size == s0, "R3 req0_size", req0_size, s0);
        end
        if (r1) begin
            chk(req1_cmd == 2'd1, "R2 req1_cmd", req1_cmd, 1);
            chk(req1_addr == ld_addr + 32'(ld_lo_size), "R3 req1_addr", req1_addr, ld_addr + 32'(ld_lo_size));
            chk(req1_size == ld_hi_size, "R3 req1_size", req1_size, ld_hi_size);
            chk(req1_offset == ld_lo_size, "R3 req1_offset", req1_offset, ld_lo_size);
        end
        chk(done_valid == dn, "R7 done_valid", done_valid, dn);
        if (dn) begin
            chk(done_idx == rsp_idx, "R7 done_idx", done_idx, rsp_idx);
            chk(done_seq == m_seq[ri], "R7 done_seq", done_seq, m_seq[ri]);
        end
        ev = go && (cache_blocked || rt);
        take = ev && (!m_bflag || ld_seq <= m_bseq);
        @(posedge clk);
        if (rsp_valid && m_cnt[ri] > 0) m_cnt[ri]--;
        if (r0 && req0_accept) begin
            m_cnt[ld_idx] = (sp && req1_accept) ? 2 : 1;
            m_seq[ld_idx] = ld_seq;
            m_alive[ld_idx] = 1;
        end
        if (squash_valid)
            for (int k = 0; k < DEPTH; k++)
                if (m_seq[k] > squash_seq) m_alive[k] = 0;
        if (take) begin
            m_bflag = 1; m_bhand = 0; m_bseq = ld_seq;
        end else begin
            if (blk_clear) m_bflag = 0;
            if (blk_handled_set) m_bhand = 1;
        end
        #1;
        chk(blk_flag == m_bflag, "R8 blk_flag", blk_flag, m_bflag);
        chk(blk_handled == m_bhand, "R9 blk_handled", blk_handled, m_bhand);
        if (m_bflag) chk(blk_seq == m_bseq, "R8 blk_seq", blk_seq, m_bseq);
        @(negedge clk);
        idle();
    endtask

    task automatic load(input int idx, input logic [ADDR_W-1:0] a, input bit split);
        ld_valid = 1; ld_idx = IDX_W'(idx); seq_ctr++; ld_seq = seq_ctr;
        ld_addr = a; ld_size = 4'd8; ld_split = split; ld_lo_size = 4'd3; ld_hi_size = 4'd5;
        ld_at_head = 1; ld_at_commit = 1;
    endtask

    task automatic resp(input int idx);
        rsp_valid = 1; rsp_idx = IDX_W'(idx);
    endtask

    initial begin
        #150000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int dummy;
        dummy = $urandom(32'd777);
        idle();
        for (int k = 0; k < DEPTH; k++) begin m_cnt[k] = 0; m_alive[k] = 0; m_seq[k] = 0; end
        m_bflag = 0; m_bhand = 0; m_bseq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R11 reset state
        chk(!req0_valid && !req1_valid && !retry_req && !resched && !done_valid, "R11 outputs idle",
            {req0_valid, req1_valid, retry_req, resched, done_valid}, 0);
        chk(!blk_flag && !blk_handled && fault_code == 4'h0, "R11 blocked record",
            {blk_flag, blk_handled, fault_code}, 0);
        @(negedge clk);
        // R1 uncacheable not at commit, then eligible
        load(0, 32'h100, 0); ld_uncache = 1; ld_at_commit = 0; step();
        load(0, 32'h100, 0); ld_uncache = 1; step();
        resp(0); step();
        // R2 locked ignores split
        load(1, 32'h200, 1); ld_locked = 1; step();
        resp(1); step();
        // R3/R7 split needs two responses
        load(2, 32'h2FE, 1); step();
        resp(2); step();
        resp(2); step();
        // R5 first refused, then reissue same index
        load(3, 32'h300, 1); req0_accept = 0; step();
        load(3, 32'h300, 0); step();
        resp(3); step();
        // R6 second refused
        load(4, 32'h400, 1); req1_accept = 0; step();
        resp(4); step();
        // R8 cache blocked: older wins, younger ignored
        load(5, 32'h500, 0); ld_seq = 16'h0900; cache_blocked = 1; step();
        load(5, 32'h500, 0); ld_seq = 16'h0950; cache_blocked = 1; step();
        load(5, 32'h500, 0); ld_seq = 16'h0800; cache_blocked = 1; step();
        // R9 handled then clear
        blk_handled_set = 1; step();
        blk_clear = 1; step();
        // R10 squash removes completion
        load(6, 32'h600, 0); step();
        squash_valid = 1; squash_seq = seq_ctr - 16'd1; step();
        resp(6); step();
        // random phase
        for (int it = 0; it < 3000; it++) begin
            int fi, bi;
            fi = -1; bi = -1;
            for (int k = 0; k < DEPTH; k++) begin
                int j;
                j = int'(($urandom + 32'(k)) % DEPTH);
                if (m_cnt[j] == 0 && fi < 0) fi = j;
                if (m_cnt[j] > 0 && bi < 0) bi = j;
            end
            if (fi >= 0 && ($urandom % 2) == 0) begin
                load(fi, $urandom, 1'($urandom));
                ld_size = SZ_W'($urandom % 9); ld_lo_size = SZ_W'($urandom % 8);
                ld_hi_size = SZ_W'($urandom % 8);
                ld_uncache = ($urandom % 4) == 0; ld_locked = ($urandom % 4) == 0;
                ld_at_head = ($urandom % 3) != 0; ld_at_commit = ($urandom % 3) != 0;
                cache_blocked = ($urandom % 8) == 0;
                req0_accept = ($urandom % 6) != 0; req1_accept = ($urandom % 6) != 0;
            end
            if (bi >= 0 && bi != fi && ($urandom % 2) == 0) resp(bi);
            if (($urandom % 20) == 0) begin squash_valid = 1; squash_seq = seq_ctr - SEQ_W'($urandom % 4); end
            if (($urandom % 10) == 0) blk_clear = 1;
            if (($urandom % 10) == 0) blk_handled_set = 1;
            step();
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule